// File: doc/BRIEF.md
# UART Mode Control with Address Filtering

This block holds the byte-wide mode register of a UART and the control logic that the register's bits drive. Software writes and reads the register over a simple strobe bus. The serializer, deserializer, baud generator and DMA engine sit outside the block. The UART reports its receive and transmit events to the block as single-cycle pulses. The block then produces:

- the line-level controls: a transmit-low override and an active-low request-to-send pin;
- the clock-source select for synchronous operation;
- the interrupt and DMA request pulses;
- a qualifier that says whether the current received character is passed on.

In address-filter (attention) mode, only 9-bit characters with the top bit set get through. The first such address character is delivered, and it also clears the attention bit in hardware, so the data characters that follow are accepted. A DMA enable takes a data event away from the matching interrupt. A clear-to-send input is synchronized inside the block, and its level changes can raise a sticky flow-control interrupt.

Top module: `uart_mode_ctl`

## Requirements
- R1: After reset, the register reads 0x00, `rts_n` is 1, `txd_low` is 0, `clk_sel_ext` is 0, and every request output (`rx_irq`, `tx_irq`, `err_irq`, `rx_dma_req`, `tx_dma_req`, `flow_irq`) is 0.
- R2: A write (`reg_wr`=1) loads all 8 bits of `reg_wdata` at the clock edge, and `reg_rdata` shows them from the next cycle on. The bit positions are: 0 synchronous mode, 1 attention, 2 break, 3 external clock, 4 transmit DMA, 5 receive DMA, 6 flow interrupt enable, 7 ready-to-send.
- R3: `txd_low` equals bit 2, and it stays 1 until software writes bit 2 back to 0.
- R4: `rts_n` is the inverse of bit 7.
- R5: `clk_sel_ext` is 1 only when bit 0 and bit 3 are both 1. In asynchronous mode (bit 0 = 0), bit 3 has no effect.
- R6: While bit 1 is 1, a character with bit 8 = 0 gives `rx_accept` = 0 in its cycle and raises neither `rx_irq` nor `rx_dma_req`. Bit 1 stays set.
- R7: While bit 1 is 1, a character with bit 8 = 1 gives `rx_accept` = 1 in its cycle, and bit 1 reads 0 from the next cycle on.
- R8: If a write and a hardware clear of bit 1 fall in the same cycle, bit 1 becomes 0 and the other seven bits take the written values.
- R9: One cycle after an accepted character, `rx_dma_req` pulses if bit 5 is 1. Otherwise `rx_irq` pulses if `rx_ie` is 1. While bit 5 is 1, `rx_irq` stays 0.
- R10: One cycle after `rx_err` with `err_ie` = 1, `err_irq` pulses, whatever the value of bit 5.
- R11: One cycle after `tx_empty`, `tx_dma_req` pulses if bit 4 is 1. Otherwise `tx_irq` pulses if `tx_ie` is 1.
- R12: A level change on `cts_n` sets `flow_irq` at the third rising edge after the change, provided bit 6 is 1. The flag stays set until `reg_rd` or `flow_ack` is seen. With bit 6 = 0, a change sets nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (also clears the flow flag) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Current register contents |
| rx_frame_vld | input | 1 | Received-character pulse |
| rx_frame | input | 9 | Received 9-bit character |
| rx_err | input | 1 | Receive error pulse |
| tx_empty | input | 1 | Transmit buffer empty pulse |
| rx_ie | input | 1 | Receive data interrupt enable |
| tx_ie | input | 1 | Transmit interrupt enable |
| err_ie | input | 1 | Receive error interrupt enable |
| cts_n | input | 1 | Clear-to-send pin, asynchronous |
| flow_ack | input | 1 | Flow interrupt acknowledge |
| txd_low | output | 1 | Forces the transmit line low |
| rts_n | output | 1 | Request-to-send pin, active low |
| clk_sel_ext | output | 1 | 1 selects the external clock, 0 the internal baud clock |
| rx_accept | output | 1 | Current character is passed on |
| rx_irq | output | 1 | Receive data interrupt pulse |
| tx_irq | output | 1 | Transmit interrupt pulse |
| err_irq | output | 1 | Receive error interrupt pulse |
| rx_dma_req | output | 1 | Receive DMA request pulse |
| tx_dma_req | output | 1 | Transmit DMA request pulse |
| flow_irq | output | 1 | Sticky flow-control interrupt |

## Verification
The assertions check on every cycle the rules that link one cycle to the next:

- a write of bit 7 or bit 2 reaches `rts_n` and `txd_low`;
- an address character clears attention;
- a data character in attention mode is rejected;
- a set DMA enable keeps the matching interrupt quiet;
- asynchronous mode never selects the external clock.

Only the bench scenarios can show the rest: the same-cycle write-versus-clear priority on the other seven bits, the three-edge latency and stickiness of the flow flag, and the order of delivery when attention mode is left.

// File: rtl/umc_pkg.sv
package umc_pkg;
    localparam int REG_W  = 8;
    localparam int CHAR_W = 9;

    // Field order is MSB first and matches the software bit positions.
    typedef struct packed {
        logic rts;
        logic fce;
        logic rx_dma;
        logic tx_dma;
        logic ck_ext;
        logic brk;
        logic attn;
        logic sync;
    } mode_t;

    typedef struct packed {
        logic rx_irq;
        logic tx_irq;
        logic err_irq;
        logic rx_dma;
        logic tx_dma;
    } req_t;
endpackage

// File: rtl/umc_mode_reg.sv
module umc_mode_reg
    import umc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wdata,
    input  logic             hw_attn_clr,
    output mode_t            mode_q
);
    mode_t mode_d;

    always_comb begin
        mode_d = mode_q;
        if (wr_en) begin
            mode_d = mode_t'(wdata);
        end
        // The hardware clear outranks software for the attention bit.
        if (hw_attn_clr) begin
            mode_d.attn = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else begin
            mode_q <= mode_d;
        end
    end
endmodule

// File: rtl/umc_attn_filter.sv
module umc_attn_filter #(
    parameter int CW = 9
) (
    input  logic          frame_vld,
    input  logic [CW-1:0] frame,
    input  logic          attn_on,
    output logic          accept,
    output logic          attn_clr
);
    localparam int ADDR_BIT = CW - 1;

    logic is_addr;

    always_comb begin
        is_addr  = frame[ADDR_BIT];
        accept   = frame_vld & (~attn_on | is_addr);
        attn_clr = frame_vld & attn_on & is_addr;
    end
endmodule

// File: rtl/umc_req_gen.sv
module umc_req_gen
    import umc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_t mode,
    input  logic  rx_evt,
    input  logic  tx_evt,
    input  logic  err_evt,
    input  logic  rx_ie,
    input  logic  tx_ie,
    input  logic  err_ie,
    output req_t  req_q
);
    req_t req_d;

    always_comb begin
        req_d         = '0;
        // A DMA enable takes the data event away from the interrupt.
        req_d.rx_dma  = rx_evt & mode.rx_dma;
        req_d.rx_irq  = rx_evt & ~mode.rx_dma & rx_ie;
        req_d.tx_dma  = tx_evt & mode.tx_dma;
        req_d.tx_irq  = tx_evt & ~mode.tx_dma & tx_ie;
        // Error interrupts do not depend on the DMA enables.
        req_d.err_irq = err_evt & err_ie;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end
endmodule

// File: rtl/umc_flow_irq.sv
module umc_flow_irq #(
    parameter int   SYNC_STAGES = 2,
    parameter logic CTS_IDLE    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cts_n,
    input  logic enable,
    input  logic clr,
    output logic pend
);
    localparam int TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
        logic                   prev;
        logic                   pend;
    } st_t;

    st_t                    st_d, st_q;
    logic [SYNC_STAGES-1:0] chain_nxt;
    logic                   change;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            assign chain_nxt = cts_n;
        end else begin : g_many
            assign chain_nxt = {st_q.chain[SYNC_STAGES-2:0], cts_n};
        end
    endgenerate

    always_comb begin
        st_d       = st_q;
        change     = st_q.chain[TOP] ^ st_q.prev;
        st_d.chain = chain_nxt;
        st_d.prev  = st_q.chain[TOP];
        // A new change wins over a clear in the same cycle, so no event is lost.
        st_d.pend  = (st_q.pend & ~clr) | (enable & change);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{chain: {SYNC_STAGES{CTS_IDLE}}, prev: CTS_IDLE, pend: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign pend = st_q.pend;
endmodule

// File: rtl/uart_mode_ctl.sv
module uart_mode_ctl
    import umc_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              rx_frame_vld,
    input  logic [CHAR_W-1:0] rx_frame,
    input  logic              rx_err,
    input  logic              tx_empty,
    input  logic              rx_ie,
    input  logic              tx_ie,
    input  logic              err_ie,
    input  logic              cts_n,
    input  logic              flow_ack,
    output logic              txd_low,
    output logic              rts_n,
    output logic              clk_sel_ext,
    output logic              rx_accept,
    output logic              rx_irq,
    output logic              tx_irq,
    output logic              err_irq,
    output logic              rx_dma_req,
    output logic              tx_dma_req,
    output logic              flow_irq
);
    mode_t mode_q;
    req_t  req_q;
    logic  attn_clr;

    umc_mode_reg u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (reg_wr),
        .wdata       (reg_wdata),
        .hw_attn_clr (attn_clr),
        .mode_q      (mode_q)
    );

    umc_attn_filter #(.CW(CHAR_W)) u_filt (
        .frame_vld (rx_frame_vld),
        .frame     (rx_frame),
        .attn_on   (mode_q.attn),
        .accept    (rx_accept),
        .attn_clr  (attn_clr)
    );

    umc_req_gen u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode_q),
        .rx_evt  (rx_accept),
        .tx_evt  (tx_empty),
        .err_evt (rx_err),
        .rx_ie   (rx_ie),
        .tx_ie   (tx_ie),
        .err_ie  (err_ie),
        .req_q   (req_q)
    );

    umc_flow_irq #(.SYNC_STAGES(SYNC_STAGES), .CTS_IDLE(1'b1)) u_flow (
        .clk    (clk),
        .rst_n  (rst_n),
        .cts_n  (cts_n),
        .enable (mode_q.fce),
        .clr    (reg_rd | flow_ack),
        .pend   (flow_irq)
    );

    assign reg_rdata   = mode_q;
    assign txd_low     = mode_q.brk;
    assign rts_n       = ~mode_q.rts;
    assign clk_sel_ext = mode_q.sync & mode_q.ck_ext;
    assign rx_irq      = req_q.rx_irq;
    assign tx_irq      = req_q.tx_irq;
    assign err_irq     = req_q.err_irq;
    assign rx_dma_req  = req_q.rx_dma;
    assign tx_dma_req  = req_q.tx_dma;
endmodule

// File: rtl/umc_checker.sv
module umc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic       rx_frame_vld,
    input logic [8:0] rx_frame,
    input logic       tx_empty,
    input logic       txd_low,
    input logic       rts_n,
    input logic       clk_sel_ext,
    input logic       rx_accept,
    input logic       rx_irq,
    input logic       tx_irq
);
    AST_RTS_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (rts_n == ~$past(reg_wdata[7])));  // R4
    AST_BREAK_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (txd_low == $past(reg_wdata[2])));  // R3
    AST_ADDR_CLEARS_ATTN: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_frame_vld && reg_rdata[1] && rx_frame[8]) |=> !reg_rdata[1]);  // R7
    AST_DATA_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_frame_vld && reg_rdata[1] && !rx_frame[8]) |-> !rx_accept);  // R6
    AST_RXDMA_MUTES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_frame_vld && reg_rdata[5]) |=> !rx_irq);  // R9
    AST_TXDMA_MUTES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && reg_rdata[4]) |=> !tx_irq);  // R11
    AST_ASYNC_INTERNAL_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rdata[0] |-> !clk_sel_ext);  // R5
endmodule

bind uart_mode_ctl umc_checker u_chk (.*);

// File: tb/uart_mode_ctl_test.sv
module uart_mode_ctl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 0, reg_rd = 0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       rx_frame_vld = 0;
    logic [8:0] rx_frame = '0;
    logic       rx_err = 0, tx_empty = 0;
    logic       rx_ie = 0, tx_ie = 0, err_ie = 0;
    logic       cts_n = 1'b1, flow_ack = 0;
    logic       txd_low, rts_n, clk_sel_ext, rx_accept;
    logic       rx_irq, tx_irq, err_irq, rx_dma_req, tx_dma_req, flow_irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        string tag;
        string sig;
        int    exp;
    } item_t;
    item_t q[$];
    event  chk_ev;

    always #10 clk = ~clk;  // 50 MHz

    uart_mode_ctl uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .rx_frame_vld(rx_frame_vld), .rx_frame(rx_frame), .rx_err(rx_err),
        .tx_empty(tx_empty), .rx_ie(rx_ie), .tx_ie(tx_ie), .err_ie(err_ie),
        .cts_n(cts_n), .flow_ack(flow_ack), .txd_low(txd_low), .rts_n(rts_n),
        .clk_sel_ext(clk_sel_ext), .rx_accept(rx_accept), .rx_irq(rx_irq),
        .tx_irq(tx_irq), .err_irq(err_irq), .rx_dma_req(rx_dma_req),
        .tx_dma_req(tx_dma_req), .flow_irq(flow_irq)
    );

    function automatic int observe(string s);
        case (s)
            "rdata":  return int'(reg_rdata);
            "txd":    return int'(txd_low);
            "rts_n":  return int'(rts_n);
            "clksel": return int'(clk_sel_ext);
            "accept": return int'(rx_accept);
            "rx_irq": return int'(rx_irq);
            "tx_irq": return int'(tx_irq);
            "err":    return int'(err_irq);
            "rx_dma": return int'(rx_dma_req);
            "tx_dma": return int'(tx_dma_req);
            "flow":   return int'(flow_irq);
            default:  return -1;
        endcase
    endfunction

    // Monitor: pops expected items and compares them with the outputs.
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                item_t it;
                int    act;
                it  = q.pop_front();
                act = observe(it.sig);
                total++;
                if (act != it.exp) begin
                    bad++;
                    $display("FAIL %s %s actual=%0d expected=%0d", it.tag, it.sig, act, it.exp);
                end
            end
        end
    end

    // Driver side: push an expectation and hand it to the monitor.
    task automatic expect_val(string tag, string sig, int exp);
        item_t it;
        it.tag = tag;
        it.sig = sig;
        it.exp = exp;
        q.push_back(it);
        ->chk_ev;
        #1;
    endtask

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic wr(logic [7:0] d);
        reg_wr    = 1'b1;
        reg_wdata = d;
        step();
        reg_wr    = 1'b0;
    endtask

    task automatic frame(logic [8:0] f);
        rx_frame_vld = 1'b1;
        rx_frame     = f;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        step(2);
        rst_n = 1'b1;
        step();
        // R1 reset state
        expect_val("R1", "rdata", 0);
        expect_val("R1", "rts_n", 1);
        expect_val("R1", "txd", 0);
        expect_val("R1", "clksel", 0);
        expect_val("R1", "rx_irq", 0);
        expect_val("R1", "flow", 0);

        // R2, R3, R4: write and readback, break, RTS
        wr(8'h84);
        expect_val("R2", "rdata", 8'h84);
        expect_val("R4", "rts_n", 0);
        expect_val("R3", "txd", 1);
        step(5);
        expect_val("R3", "txd", 1);
        wr(8'h00);
        expect_val("R3", "txd", 0);
        expect_val("R4", "rts_n", 1);
        wr(8'h5A);
        expect_val("R2", "rdata", 8'h5A);

        // R5 clock source only in synchronous mode
        wr(8'h08);
        expect_val("R5", "clksel", 0);
        wr(8'h09);
        expect_val("R5", "clksel", 1);
        wr(8'h01);
        expect_val("R5", "clksel", 0);

        // R6, R7, R9 attention filtering
        rx_ie = 1'b1;
        wr(8'h02);
        frame(9'h055);
        expect_val("R6", "accept", 0);
        step();
        rx_frame_vld = 1'b0;
        expect_val("R6", "rx_irq", 0);
        expect_val("R6", "rx_dma", 0);
        expect_val("R6", "rdata", 8'h02);
        frame(9'h1AB);
        expect_val("R7", "accept", 1);
        step();
        rx_frame_vld = 1'b0;
        expect_val("R7", "rdata", 8'h00);
        expect_val("R9", "rx_irq", 1);
        step();
        expect_val("R9", "rx_irq", 0);
        frame(9'h055);
        expect_val("R6", "accept", 1);
        step();
        rx_frame_vld = 1'b0;
        expect_val("R9", "rx_irq", 1);

        // R8 hardware clear outranks a same-cycle write
        wr(8'h02);
        frame(9'h101);
        reg_wr    = 1'b1;
        reg_wdata = 8'h82;
        step();
        reg_wr       = 1'b0;
        rx_frame_vld = 1'b0;
        expect_val("R8", "rdata", 8'h80);

        // R9 receive DMA, R10 errors
        wr(8'h20);
        frame(9'h033);
        step();
        rx_frame_vld = 1'b0;
        expect_val("R9", "rx_dma", 1);
        expect_val("R9", "rx_irq", 0);
        err_ie = 1'b1;
        rx_err = 1'b1;
        step();
        rx_err = 1'b0;
        expect_val("R10", "err", 1);
        err_ie = 1'b0;
        rx_err = 1'b1;
        step();
        rx_err = 1'b0;
        expect_val("R10", "err", 0);

        // R11 transmit
        wr(8'h00);
        tx_ie    = 1'b1;
        tx_empty = 1'b1;
        step();
        tx_empty = 1'b0;
        expect_val("R11", "tx_irq", 1);
        expect_val("R11", "tx_dma", 0);
        wr(8'h10);
        tx_empty = 1'b1;
        step();
        tx_empty = 1'b0;
        expect_val("R11", "tx_dma", 1);
        expect_val("R11", "tx_irq", 0);

        // R12 flow control
        wr(8'h00);
        cts_n = 1'b0;
        step(4);
        expect_val("R12", "flow", 0);
        wr(8'h40);
        cts_n = 1'b1;
        step(2);
        expect_val("R12", "flow", 0);
        step();
        expect_val("R12", "flow", 1);
        step(3);
        expect_val("R12", "flow", 1);
        reg_rd = 1'b1;
        step();
        reg_rd = 1'b0;
        expect_val("R12", "flow", 0);
        cts_n = 1'b0;
        step(3);
        expect_val("R12", "flow", 1);
        flow_ack = 1'b1;
        step();
        flow_ack = 1'b0;
        expect_val("R12", "flow", 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule